// File: doc/BRIEF.md
# ADC Sample Page Packer with CRC

This block turns the continuous stream of signed 14-bit samples from one receiver channel into fixed-size memory pages ready for a wide memory write port. Every page opens with a 64-bit time stamp, which is the sample sequence number of the first sample in the page. Next come the samples, packed end to end into 64-bit words with no padding. A 64-bit CRC word closes the page. The 64-bit page words are then grouped four at a time into 256-bit beats, and markers flag the first and last beat of each page.

With the default settings a page holds 4672 samples. These fill exactly 1022 data words, so with the stamp and the CRC a page is 1024 words, or 8192 bytes, delivered as 256 beats. At a 5 ns sample period one page covers 23.36 µs. A one-cycle start strobe loads the first sequence number and arms the block. From then on the stamp advances by the page sample count on every page. When the memory side stalls, the stall travels back to the sample input through a ready signal.

Top module: `adc_page_packer`

## Requirements
- R1: After reset `beat_valid_o` is low and `smp_ready_o` is high.
- R2: Before the block is armed, samples are accepted and discarded, and no beat is produced. This covers samples offered in the cycle of the start strobe. The first sample accepted after that cycle is sample 0 of page 0.
- R3: Page word 0 of page p equals the start value on `ssn_i` plus p×PAGE_SAMPLES, modulo 2^64.
- R4: Within a page, sample n occupies bits [14n+13:14n] of the data region, with no gaps. Page word j (1 ≤ j ≤ DATA_WORDS) holds data-region bits [64(j−1)+63:64(j−1)].
- R5: The last page word is a 64-bit CRC with polynomial 0x42F0E1EBA9EA3693 and initial value all ones. It covers the stamp word and all data words, each word processed from bit 63 down to bit 0, with no final inversion.
- R6: Beat b of a page carries page word 4b+i in bits [64i+63:64i], so the earliest word sits in the lowest lane.
- R7: `beat_sop_o` is high only on the first beat of a page and `beat_eop_o` only on the last.
- R8: While `beat_valid_o` is high and `beat_ready_i` is low, the beat and its markers stay unchanged. Under any pattern of stalls, no sample is lost or repeated.
- R9: Pages follow one another with no leftover bits. Each page holds exactly PAGE_SAMPLES samples, PAGE_SAMPLES×14/64+2 words and that count divided by 4 beats (4672, 1024 and 256 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that arms the block and loads the sequence number |
| ssn_i | input | 64 | Sequence number of the first page |
| smp_valid_i | input | 1 | Sample present |
| smp_data_i | input | 14 | Signed sample |
| smp_ready_o | output | 1 | Sample accepted this cycle when valid |
| beat_valid_o | output | 1 | Beat present |
| beat_ready_i | input | 1 | Memory side takes the beat |
| beat_data_o | output | 256 | Four page words, earliest in the lowest lane |
| beat_sop_o | output | 1 | First beat of a page |
| beat_eop_o | output | 1 | Last beat of a page |

## Verification
A wrong bit position in the packer shows up in the first data beat of page 0. A lost or repeated sample shifts every later field, and the CRC lane of that same page catches it within one page time. A wrong word count in the page sequencer moves the markers and the stamp lane by the next page boundary. A stamp that advances by the wrong amount is visible in the stamp of the second page. Stall faults are exposed within one cycle, because a held beat changes while ready is low.

// File: rtl/page_pkg.sv
`timescale 1ns/1ps
package page_pkg;
  localparam logic [63:0] CRC64_POLY = 64'h42F0E1EBA9EA3693;
  localparam int DEF_SAMPLE_W     = 14;
  localparam int DEF_WORD_W       = 64;
  localparam int DEF_LANES        = 4;
  localparam int DEF_PAGE_SAMPLES = 4672;
endpackage

// File: rtl/page_bitpack.sv
`timescale 1ns/1ps
module page_bitpack #(
  parameter int SAMPLE_W = 14,
  parameter int WORD_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid_i,
  input  logic [SAMPLE_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              w_valid_o,
  output logic [WORD_W-1:0] w_data_o,
  input  logic              w_ready_i
);
  localparam int ACC_W = WORD_W + SAMPLE_W;
  localparam int SUM_W = $clog2(ACC_W);

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]  fill_q, fill_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              wv_q, wv_d;
  logic [ACC_W-1:0]  merged;
  logic [SUM_W-1:0]  sum;
  logic              take;

  assign s_ready_o = !wv_q || w_ready_i;
  assign take      = s_valid_i && s_ready_o;
  assign merged    = ACC_W'(acc_q) | (ACC_W'(s_data_i) << fill_q);
  assign sum       = fill_q + SUM_W'(SAMPLE_W);

  always_comb begin
    acc_d  = acc_q;
    fill_d = fill_q;
    word_d = word_q;
    wv_d   = wv_q && !w_ready_i;
    if (take) begin
      if (sum >= SUM_W'(WORD_W)) begin
        word_d = merged[WORD_W-1:0];
        wv_d   = 1'b1;
        acc_d  = WORD_W'(merged >> WORD_W);
        fill_d = sum - SUM_W'(WORD_W);
      end else begin
        acc_d  = merged[WORD_W-1:0];
        fill_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      word_q <= '0;
      wv_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      word_q <= word_d;
      wv_q   <= wv_d;
    end
  end

  assign w_valid_o = wv_q;
  assign w_data_o  = word_q;

  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q && !w_ready_i |=> wv_q && $stable(word_q));
endmodule

// File: rtl/page_framer.sv
`timescale 1ns/1ps
module page_framer #(
  parameter int WORD_W       = 64,
  parameter int DATA_WORDS   = 1022,
  parameter int PAGE_SAMPLES = 4672,
  parameter logic [WORD_W-1:0] POLY = page_pkg::CRC64_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] ssn_i,
  input  logic              run_i,
  input  logic              p_valid_i,
  input  logic [WORD_W-1:0] p_data_i,
  output logic              p_ready_o,
  output logic              f_valid_o,
  output logic [WORD_W-1:0] f_data_o,
  output logic              f_first_o,
  output logic              f_last_o,
  input  logic              f_ready_i
);
  localparam int PAGE_WORDS = DATA_WORDS + 2;
  localparam int IDX_W      = $clog2(PAGE_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAGE_WORDS - 1);

  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    logic fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ d[i];
      r  = {r[WORD_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] ssn_q, ssn_d, crc_q, crc_d;
  logic [WORD_W-1:0] out_q, out_d;
  logic              ov_q, ov_d, first_q, first_d, last_q, last_d;
  logic              can_load, is_hdr, is_crc, is_dat, src_ok, take;
  logic [WORD_W-1:0] sel;

  assign can_load  = !ov_q || f_ready_i;
  assign is_hdr    = (idx_q == '0);
  assign is_crc    = (idx_q == IDX_LAST);
  assign is_dat    = !is_hdr && !is_crc;
  assign src_ok    = is_hdr ? run_i : (is_dat ? p_valid_i : 1'b1);
  assign take      = can_load && src_ok;
  assign p_ready_o = can_load && is_dat;
  assign sel       = is_hdr ? ssn_q : (is_dat ? p_data_i : crc_q);

  always_comb begin
    idx_d   = idx_q;
    ssn_d   = ssn_q;
    crc_d   = crc_q;
    out_d   = out_q;
    first_d = first_q;
    last_d  = last_q;
    ov_d    = ov_q && !f_ready_i;
    if (load_i) ssn_d = ssn_i;
    if (take) begin
      out_d   = sel;
      ov_d    = 1'b1;
      first_d = is_hdr;
      last_d  = is_crc;
      idx_d   = is_crc ? '0 : idx_q + 1'b1;
      crc_d   = crc_step(is_hdr ? '1 : crc_q, sel);
      if (is_hdr) ssn_d = ssn_q + WORD_W'(PAGE_SAMPLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ssn_q   <= '0;
      crc_q   <= '1;
      out_q   <= '0;
      ov_q    <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      ssn_q   <= ssn_d;
      crc_q   <= crc_d;
      out_q   <= out_d;
      ov_q    <= ov_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  assign f_valid_o = ov_q;
  assign f_data_o  = out_q;
  assign f_first_o = first_q;
  assign f_last_o  = last_q;

  p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q && !f_ready_i |=> ov_q && $stable(out_q) && $stable(first_q) && $stable(last_q));
  p_first_not_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q && first_q |-> !last_q);
endmodule

// File: rtl/page_widen.sv
`timescale 1ns/1ps
module page_widen #(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    n_valid_i,
  input  logic [WORD_W-1:0]       n_data_i,
  input  logic                    n_first_i,
  input  logic                    n_last_i,
  output logic                    n_ready_o,
  output logic                    b_valid_o,
  output logic [LANES*WORD_W-1:0] b_data_o,
  output logic                    b_sop_o,
  output logic                    b_eop_o,
  input  logic                    b_ready_i
);
  localparam int LN_W = $clog2(LANES);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(LANES - 1);

  logic [LANES-2:0][WORD_W-1:0] hold_q, hold_d;
  logic [LN_W-1:0]              lane_q, lane_d;
  logic                         sopp_q, sopp_d;
  logic [LANES*WORD_W-1:0]      bd_q, bd_d;
  logic                         bv_q, bv_d, bs_q, bs_d, be_q, be_d;
  logic                         fire;

  assign n_ready_o = (lane_q != LN_LAST) || !bv_q || b_ready_i;
  assign fire      = n_valid_i && n_ready_o;

  always_comb begin
    hold_d = hold_q;
    lane_d = lane_q;
    sopp_d = sopp_q;
    bd_d   = bd_q;
    bs_d   = bs_q;
    be_d   = be_q;
    bv_d   = bv_q && !b_ready_i;
    if (fire) begin
      if (lane_q == LN_LAST) begin
        for (int i = 0; i < LANES - 1; i++) bd_d[i*WORD_W +: WORD_W] = hold_q[i];
        bd_d[(LANES-1)*WORD_W +: WORD_W] = n_data_i;
        bv_d   = 1'b1;
        bs_d   = sopp_q;
        be_d   = n_last_i;
        lane_d = '0;
      end else begin
        hold_d[lane_q] = n_data_i;
        if (lane_q == '0) sopp_d = n_first_i;
        lane_d = lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      lane_q <= '0;
      sopp_q <= 1'b0;
      bd_q   <= '0;
      bv_q   <= 1'b0;
      bs_q   <= 1'b0;
      be_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      lane_q <= lane_d;
      sopp_q <= sopp_d;
      bd_q   <= bd_d;
      bv_q   <= bv_d;
      bs_q   <= bs_d;
      be_q   <= be_d;
    end
  end

  assign b_valid_o = bv_q;
  assign b_data_o  = bd_q;
  assign b_sop_o   = bs_q;
  assign b_eop_o   = be_q;

  p_beat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q && !b_ready_i |=> bv_q && $stable(bd_q) && $stable(bs_q) && $stable(be_q));
  p_sop_eop_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> !(bs_q && be_q));
endmodule

// File: rtl/adc_page_packer.sv
`timescale 1ns/1ps
module adc_page_packer #(
  parameter int SAMPLE_W     = page_pkg::DEF_SAMPLE_W,
  parameter int WORD_W       = page_pkg::DEF_WORD_W,
  parameter int LANES        = page_pkg::DEF_LANES,
  parameter int PAGE_SAMPLES = page_pkg::DEF_PAGE_SAMPLES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [WORD_W-1:0]       ssn_i,
  input  logic                    smp_valid_i,
  input  logic [SAMPLE_W-1:0]     smp_data_i,
  output logic                    smp_ready_o,
  output logic                    beat_valid_o,
  input  logic                    beat_ready_i,
  output logic [LANES*WORD_W-1:0] beat_data_o,
  output logic                    beat_sop_o,
  output logic                    beat_eop_o
);
  localparam int DATA_WORDS = PAGE_SAMPLES * SAMPLE_W / WORD_W;

  logic rst_meta_q, rst_sync_q;
  logic armed_q, armed_d;
  logic pk_s_ready, pk_valid, pk_ready;
  logic [WORD_W-1:0] pk_data;
  logic fr_valid, fr_first, fr_last, fr_ready;
  logic [WORD_W-1:0] fr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign armed_d = armed_q || start_i;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) armed_q <= 1'b0;
    else             armed_q <= armed_d;
  end

  assign smp_ready_o = armed_q ? pk_s_ready : 1'b1;

  page_bitpack #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) pack_i (
    .clk(clk), .rst_n(rst_sync_q),
    .s_valid_i(smp_valid_i && armed_q), .s_data_i(smp_data_i), .s_ready_o(pk_s_ready),
    .w_valid_o(pk_valid), .w_data_o(pk_data), .w_ready_i(pk_ready));

  page_framer #(.WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS), .PAGE_SAMPLES(PAGE_SAMPLES)) frame_i (
    .clk(clk), .rst_n(rst_sync_q),
    .load_i(start_i && !armed_q), .ssn_i(ssn_i), .run_i(armed_q),
    .p_valid_i(pk_valid), .p_data_i(pk_data), .p_ready_o(pk_ready),
    .f_valid_o(fr_valid), .f_data_o(fr_data), .f_first_o(fr_first), .f_last_o(fr_last),
    .f_ready_i(fr_ready));

  page_widen #(.WORD_W(WORD_W), .LANES(LANES)) widen_i (
    .clk(clk), .rst_n(rst_sync_q),
    .n_valid_i(fr_valid), .n_data_i(fr_data), .n_first_i(fr_first), .n_last_i(fr_last),
    .n_ready_o(fr_ready),
    .b_valid_o(beat_valid_o), .b_data_o(beat_data_o), .b_sop_o(beat_sop_o),
    .b_eop_o(beat_eop_o), .b_ready_i(beat_ready_i));

  p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !armed_q |-> !beat_valid_o && !fr_valid);
endmodule

// File: tb/adc_page_packer_tb_top.sv
`timescale 1ns/1ps
module adc_page_packer_tb_top;
  localparam int SW    = 14;
  localparam int WW    = 64;
  localparam int LN    = 4;
  localparam int SMP   = 64;
  localparam int DW    = SMP * SW / WW;
  localparam int PW    = DW + 2;
  localparam int BEATS = PW / LN;
  localparam int PAGES = 3;
  localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;

  logic clk = 1'b0;
  logic rst_n, start_i, smp_valid_i, beat_ready_i;
  logic [WW-1:0] ssn_i;
  logic [SW-1:0] smp_data_i;
  logic smp_ready_o, beat_valid_o, beat_sop_o, beat_eop_o;
  logic [LN*WW-1:0] beat_data_o;

  int total = 0;
  int bad = 0;
  int cur_mode = 0;
  logic [63:0] cur_ssn;

  always #2 clk = ~clk;

  adc_page_packer #(.SAMPLE_W(SW), .WORD_W(WW), .LANES(LN), .PAGE_SAMPLES(SMP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ssn_i(ssn_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .smp_ready_o(smp_ready_o),
    .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i), .beat_data_o(beat_data_o),
    .beat_sop_o(beat_sop_o), .beat_eop_o(beat_eop_o));

  function automatic logic [SW-1:0] gen(int k);
    logic [31:0] h;
    case (cur_mode)
      0: return SW'(k * 37 + 5);
      1: begin h = 32'(k) * 32'h9E3779B1; return h[22:9]; end
      2: return k[0] ? 14'h1FFF : 14'h2000;
      default: return (k % 3 == 0) ? 14'h3FFF : 14'h0000;
    endcase
  endfunction

  function automatic logic [63:0] plain_word(int p, int j);
    logic [63:0] w;
    logic [SW-1:0] s;
    int g;
    if (j == 0) return cur_ssn + 64'(p * SMP);
    w = '0;
    for (int b = 0; b < 64; b++) begin
      g = (j - 1) * 64 + b;
      s = gen(p * SMP + g / SW);
      w[b] = s[g % SW];
    end
    return w;
  endfunction

  function automatic logic [63:0] page_crc(int p);
    logic [63:0] c, d;
    logic fb;
    c = '1;
    for (int j = 0; j < PW - 1; j++) begin
      d = plain_word(p, j);
      for (int i = 63; i >= 0; i--) begin
        fb = c[63] ^ d[i];
        c = c << 1;
        if (fb) c = c ^ POLY;
      end
    end
    return c;
  endfunction

  function automatic logic [63:0] exp_word(int p, int j);
    if (j == PW - 1) return page_crc(p);
    return plain_word(p, j);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input int mode, input int rmode, input logic [63:0] s0);
    int k, beats, cyc, p, b, j;
    bit idle_ok, stall, hold_ok;
    logic [255:0] exp, prev_d;
    logic prev_s, prev_e;
    string tag;
    cur_mode = mode;
    cur_ssn  = s0;
    rst_n = 1'b0; start_i = 1'b0; smp_valid_i = 1'b0; beat_ready_i = 1'b0;
    smp_data_i = '0; ssn_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(beat_valid_o == 1'b0 && smp_ready_o == 1'b1, "R1", "reset state",
        256'({beat_valid_o, smp_ready_o}), 256'(2'b01));
    // R2: samples offered while not armed and during the start cycle are dropped
    idle_ok = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      smp_valid_i = 1'b1; smp_data_i = 14'h3FFF; beat_ready_i = 1'b1;
      start_i = (c == 5); ssn_i = s0;
      #1;
      if (beat_valid_o || !smp_ready_o) idle_ok = 1'b0;
    end
    chk(idle_ok, "R2", "idle drop", 256'(idle_ok), 256'(1));
    k = 0; beats = 0; cyc = 0; stall = 1'b0;
    prev_d = '0; prev_s = 1'b0; prev_e = 1'b0;
    while (beats < PAGES * BEATS && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      case (rmode)
        0: begin smp_valid_i = 1'b1; beat_ready_i = 1'b1; end
        1: begin smp_valid_i = (cyc % 5) != 0; beat_ready_i = (cyc % 3) != 0; end
        default: begin smp_valid_i = (cyc % 4) != 3; beat_ready_i = ((cyc / 7) % 2) == 1; end
      endcase
      smp_data_i = gen(k);
      #1;
      if (stall) begin
        hold_ok = beat_valid_o && beat_data_o == prev_d && beat_sop_o == prev_s
                  && beat_eop_o == prev_e;
        chk(hold_ok, "R8", "stall hold", beat_data_o, prev_d);
      end
      stall  = beat_valid_o && !beat_ready_i;
      prev_d = beat_data_o; prev_s = beat_sop_o; prev_e = beat_eop_o;
      if (smp_valid_i && smp_ready_o) k++;
      if (beat_valid_o && beat_ready_i) begin
        p = beats / BEATS;
        b = beats % BEATS;
        for (int i = 0; i < LN; i++) exp[i*64 +: 64] = exp_word(p, b * LN + i);
        if (beat_data_o !== exp) begin
          for (int i = 0; i < LN; i++) begin
            j = b * LN + i;
            tag = (j == 0) ? ((p > 0) ? "R9/R3" : "R3") : ((j == PW - 1) ? "R5" : "R4/R8");
            if (beat_data_o[i*64 +: 64] !== exp[i*64 +: 64])
              $display("FAIL %s R6 page %0d word %0d actual=%h expected=%h", tag, p, j,
                       beat_data_o[i*64 +: 64], exp[i*64 +: 64]);
          end
        end
        total++;
        if (beat_data_o !== exp) bad++;
        chk(beat_sop_o == (b == 0) && beat_eop_o == (b == BEATS - 1), "R7", "markers",
            256'({beat_sop_o, beat_eop_o}), 256'({b == 0, b == BEATS - 1}));
        beats++;
      end
    end
    chk(beats == PAGES * BEATS, "R9", "page count / watchdog", 256'(beats),
        256'(PAGES * BEATS));
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 3; r++)
        run(m, r, (m == 3) ? 64'hFFFF_FFFF_FFFF_FFA0 : 64'(1000 * m + 17 * r));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule